// File: doc/BRIEF.md
# LCD Panel Suspend Power Sequencer

This block sets the order in which a flat panel loses and regains its drive power and its interface signals when the display goes into or comes out of suspend. Suspend can be requested in two ways. One is a bit in a small control register written by software. The other is an active-low pin, which is synchronised inside the block before use. The block reads a one-cycle frame-start tick from the display timing generator. From it, the block produces four registered outputs:

- a panel-drive power enable,
- a gate for the frame-sync line,
- a gate for the other panel interface lines,
- a flag telling the clock controller that clocks may now be stopped.

On entry to suspend, the power enable and the frame-sync gate drop together at a frame boundary. The interface gate then stays open for a decay window of a fixed number of frame ticks, so that the panel supply can fall to zero before the interface signals stop. On exit, the interface gate opens first. Power and frame-sync follow at the next frame boundary. The window is counted in frame ticks, so a shorter programmed frame shortens it in real time. A separate register bit lets software hold the power enable off for as long as it needs.

Top module: `lcd_suspend_seq`

## Requirements
- R1: Suspend is requested while register bit 0 is 1 or the suspend pin is low. Either source is enough on its own. A pin change reaches the sequencer on the third clock edge, after a two-flop synchroniser.
- R2: While suspend is requested in the active state, power enable and frame-sync gate stay high until a frame tick arrives. Both go low on the clock edge that samples the tick.
- R3: The frame-sync gate goes low on the same edge as the power enable. Power enable is never high while the frame-sync gate is low.
- R4: After power is dropped, the interface gate stays high through 127 further frame ticks. It goes low one clock after the edge that samples the 128th tick. The clocks-stoppable flag rises on that same edge and is high only in that suspended state.
- R5: The window counts frame ticks whatever their spacing. Ticks beyond the 128th change nothing, because the counter holds at 128.
- R6: Register bit 3 set to 1 forces the power enable low while the block is otherwise active. The frame-sync and interface gates are not affected. Power returns one edge after the bit is cleared.
- R7: Once suspend is removed in the suspended state, the interface gate reopens on the next edge without waiting for a tick. Power enable and frame-sync gate return high on the edge that samples the next frame tick.
- R8: Register writes are ignored while the synchronised suspend pin is active. Bits 0 and 3 of the register can be read on the two configuration outputs.
- R9: If suspend is removed during the decay window, the interface gate stays high. Power and frame-sync return at the next tick. A later request starts a fresh window of 128 ticks.
- R10: After reset the block is active: power, frame-sync and interface gates are high, the clocks-stoppable flag is low, and both register bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Write data: bit 0 software suspend, bit 3 force power off |
| suspend_pin_n | input | 1 | Asynchronous active-low suspend request |
| frame_tick | input | 1 | One-cycle frame-start pulse |
| panel_pwr_en | output | 1 | Panel drive power enable |
| frame_sync_en | output | 1 | Frame-sync output gate |
| iface_en | output | 1 | Gate for the other panel interface signals |
| clk_stop_ok | output | 1 | Clocks may be stopped |
| cfg_sw_suspend | output | 1 | Register bit 0 readback |
| cfg_pwr_off | output | 1 | Register bit 3 readback |

## Verification
The assertions assume that `frame_tick` is a single-cycle pulse and that reset is held from time zero until the first edges have loaded every register. They also assume that the suspend pin stays at each level long enough for the synchroniser to carry it across. The stimulus drives every input on the falling edge. It spaces ticks at least two clocks apart, and after every pin change it waits several clocks before the next tick. As a result, each expected output level is checked only after all transitions have settled.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_DECAY  = 2'd1,
    ST_SUSP   = 2'd2,
    ST_RESUME = 2'd3
  } seq_state_t;
endpackage

// File: rtl/lcd_seq_sync.sv
module lcd_seq_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= RESET_VAL;
        else if (i == 0) chain[i] <= din;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl #(
  parameter int REG_W    = 8,
  parameter int SUSP_BIT = 0,
  parameter int PWR_BIT  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             hw_susp,
  output logic             sw_susp,
  output logic             pwr_off
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sw_susp <= 1'b0;
      pwr_off <= 1'b0;
    end else if (wr_en && !hw_susp) begin
      sw_susp <= wr_data[SUSP_BIT];
      pwr_off <= wr_data[PWR_BIT];
    end
  end

  assert_wr_locked_R8: assert property (@(posedge clk) disable iff (rst)
    (hw_susp && wr_en) |=> ($stable(sw_susp) && $stable(pwr_off)));
endmodule

// File: rtl/lcd_seq_counter.sv
module lcd_seq_counter #(
  parameter int LIMIT = 128,
  parameter int W     = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         done
);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc && cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIM);

  assert_cnt_sat_R5: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIM);
  assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(done) && !$past(clr)) |-> done);
endmodule

// File: rtl/lcd_seq_fsm.sv
module lcd_seq_fsm
  import lcd_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic force_off,
  input  logic tick,
  input  logic cnt_done,
  output logic cnt_clr,
  output logic cnt_inc,
  output logic pwr_en,
  output logic fsync_en,
  output logic if_en,
  output logic stop_ok
);
  seq_state_t state, state_nxt;

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_ACTIVE: if (req && tick) state_nxt = ST_DECAY;
      ST_DECAY: begin
        if (!req) state_nxt = ST_RESUME;
        else if (cnt_done) state_nxt = ST_SUSP;
      end
      ST_SUSP:   if (!req) state_nxt = ST_RESUME;
      ST_RESUME: begin
        if (req) state_nxt = ST_DECAY;
        else if (tick) state_nxt = ST_ACTIVE;
      end
      default:   state_nxt = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_ACTIVE;
      pwr_en   <= 1'b1;
      fsync_en <= 1'b1;
      if_en    <= 1'b1;
      stop_ok  <= 1'b0;
    end else begin
      state    <= state_nxt;
      pwr_en   <= (state_nxt == ST_ACTIVE) && !force_off;
      fsync_en <= (state_nxt == ST_ACTIVE);
      if_en    <= (state_nxt != ST_SUSP);
      stop_ok  <= (state_nxt == ST_SUSP);
    end
  end

  assign cnt_clr = (state == ST_ACTIVE) || (state == ST_RESUME);
  assign cnt_inc = (state == ST_DECAY) && tick;

  assert_fsync_covers_pwr_R3: assert property (@(posedge clk) disable iff (rst)
    !fsync_en |-> !pwr_en);
  assert_drop_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(fsync_en) |-> $past(tick));
  assert_pwr_rise_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_en) |-> ($past(tick) || $past(state) == ST_ACTIVE));
  assert_if_reopen_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SUSP && !req) |=> if_en);
endmodule

// File: rtl/lcd_suspend_seq.sv
module lcd_suspend_seq #(
  parameter int DECAY_FRAMES = 128,
  parameter int SYNC_STAGES  = 2,
  parameter int REG_W        = 8,
  parameter int SUSP_BIT     = 0,
  parameter int PWR_BIT      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             suspend_pin_n,
  input  logic             frame_tick,
  output logic             panel_pwr_en,
  output logic             frame_sync_en,
  output logic             iface_en,
  output logic             clk_stop_ok,
  output logic             cfg_sw_suspend,
  output logic             cfg_pwr_off
);
  localparam int CNT_W = $clog2(DECAY_FRAMES + 1);

  logic             pin_sync_n, hw_susp, sw_susp, pwr_off, req;
  logic             cnt_clr, cnt_inc, cnt_done;
  logic [CNT_W-1:0] cnt;

  lcd_seq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .din(suspend_pin_n), .dout(pin_sync_n));

  assign hw_susp = !pin_sync_n;

  lcd_seq_ctrl #(.REG_W(REG_W), .SUSP_BIT(SUSP_BIT), .PWR_BIT(PWR_BIT)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .hw_susp(hw_susp), .sw_susp(sw_susp), .pwr_off(pwr_off));

  assign req = sw_susp || hw_susp;

  lcd_seq_counter #(.LIMIT(DECAY_FRAMES), .W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc),
    .cnt(cnt), .done(cnt_done));

  lcd_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .req(req), .force_off(pwr_off), .tick(frame_tick),
    .cnt_done(cnt_done), .cnt_clr(cnt_clr), .cnt_inc(cnt_inc),
    .pwr_en(panel_pwr_en), .fsync_en(frame_sync_en),
    .if_en(iface_en), .stop_ok(clk_stop_ok));

  assign cfg_sw_suspend = sw_susp;
  assign cfg_pwr_off    = pwr_off;

  assert_stop_after_count_R4: assert property (@(posedge clk) disable iff (rst)
    clk_stop_ok |-> (cnt_done && !iface_en));
  assert_if_close_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(iface_en) |-> $past(cnt_done));
  assert_request_sources_R1: assert property (@(posedge clk) disable iff (rst)
    (!req && iface_en && frame_sync_en) |=> frame_sync_en);
endmodule

// File: tb/lcd_suspend_seq_bench.sv
module lcd_suspend_seq_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       suspend_pin_n = 1'b1;
  logic       frame_tick = 1'b0;
  logic       panel_pwr_en, frame_sync_en, iface_en, clk_stop_ok;
  logic       cfg_sw_suspend, cfg_pwr_off;

  int checks = 0;
  int errors = 0;

  typedef struct {
    string      tag;
    logic [3:0] exp;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  lcd_suspend_seq u_lcd_suspend_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .suspend_pin_n(suspend_pin_n), .frame_tick(frame_tick),
    .panel_pwr_en(panel_pwr_en), .frame_sync_en(frame_sync_en),
    .iface_en(iface_en), .clk_stop_ok(clk_stop_ok),
    .cfg_sw_suspend(cfg_sw_suspend), .cfg_pwr_off(cfg_pwr_off));

  // monitor: compares {pwr, fsync, iface, stop} against queued expectations
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t x;
      logic [3:0] act;
      x = q.pop_front();
      act = {panel_pwr_en, frame_sync_en, iface_en, clk_stop_ok};
      checks++;
      if (act !== x.exp) begin
        errors++;
        $display("FAIL %s: outputs actual %b expected %b", x.tag, act, x.exp);
      end
    end
  end

  task automatic expect_o(input string tag, input logic [3:0] e);
    exp_t x;
    x.tag = tag;
    x.exp = e;
    q.push_back(x);
    @(negedge clk);
  endtask

  task automatic expect_cfg(input string tag, input logic [1:0] e);
    checks++;
    if ({cfg_sw_suspend, cfg_pwr_off} !== e) begin
      errors++;
      $display("FAIL %s: cfg actual %b expected %b", tag,
               {cfg_sw_suspend, cfg_pwr_off}, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(input int gap);
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic write_reg(input logic [7:0] v);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(5);
    rst = 1'b0;
    idle(2);
    expect_o("R10 reset state", 4'b1110);
    expect_cfg("R10 reset register", 2'b00);

    // software request, no tick yet
    write_reg(8'h01);
    idle(3);
    expect_o("R2 hold until tick", 4'b1110);
    tick(2);
    expect_o("R2 R3 power and sync drop on tick", 4'b0010);
    for (int i = 0; i < 127; i++) tick(3);
    expect_o("R4 interface alive after 127 ticks", 4'b0010);
    tick(2);
    expect_o("R4 suspended after 128th tick", 4'b0001);
    for (int i = 0; i < 5; i++) tick(2);
    expect_o("R5 saturated, extra ticks ignored", 4'b0001);

    // resume by software
    write_reg(8'h00);
    expect_o("R7 interface reopens without tick", 4'b0010);
    tick(2);
    expect_o("R7 power and sync back on tick", 4'b1110);

    // hardware pin request
    suspend_pin_n = 1'b0;
    idle(4);
    expect_o("R1 pin request waits for tick", 4'b1110);
    tick(2);
    expect_o("R1 pin request drops power", 4'b0010);
    write_reg(8'h09);
    expect_cfg("R8 write ignored while pin active", 2'b00);
    for (int i = 0; i < 127; i++) tick(2 + (i % 5));
    expect_o("R5 uneven spacing, 127 ticks", 4'b0010);
    tick(2);
    expect_o("R5 uneven spacing, suspended", 4'b0001);
    suspend_pin_n = 1'b1;
    idle(4);
    expect_o("R7 pin release reopens interface", 4'b0010);
    tick(2);
    expect_o("R7 pin release power on tick", 4'b1110);

    // abort during decay
    write_reg(8'h01);
    tick(2);
    for (int i = 0; i < 50; i++) tick(2);
    write_reg(8'h00);
    expect_o("R9 abort keeps interface", 4'b0010);
    tick(2);
    expect_o("R9 abort power back on tick", 4'b1110);
    write_reg(8'h01);
    tick(2);
    for (int i = 0; i < 127; i++) tick(2);
    expect_o("R9 fresh window after abort", 4'b0010);
    tick(2);
    expect_o("R9 fresh window completes", 4'b0001);
    write_reg(8'h00);
    tick(2);
    expect_o("R9 active again", 4'b1110);

    // manual power override
    write_reg(8'h08);
    expect_cfg("R6 override bit stored", 2'b01);
    expect_o("R6 power forced off", 4'b0110);
    tick(2);
    expect_o("R6 tick keeps power off", 4'b0110);
    write_reg(8'h00);
    expect_o("R6 power returns", 4'b1110);

    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule